// File: doc/BRIEF.md
# Store Buffer with Youngest-Match Load Forwarding

This block sits between one processor and memory and gives that processor total-store-order semantics. Every store the processor issues is queued in a private first-in first-out buffer. The buffer drains to memory one entry at a time over a request/acknowledge port, in exactly the order the stores were issued. The processor does not wait for a store to reach memory.

A load first looks through the queued stores for one with the same full word address. If any match, the data of the most recently issued matching store comes back in the cycle after the load is accepted, and memory is not read. If none match, the load is sent to memory as a read and its data returns in the cycle of the memory acknowledge. While a load is in progress the processor port accepts nothing. While a missing load waits for memory, no new store drain is started. A store write already presented to memory is allowed to complete first, so the memory port never withdraws a request.

The processor request port is valid/ready. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low whenever a load is in progress. It is also low for a store while the buffer holds `DEPTH` entries. The payload must be held until the transfer. The load response is a one-cycle `rsp_valid` pulse with no back-pressure, because the processor is stalled until it arrives. On the memory port, `mem_req` and its payload stay stable until a cycle in which `mem_ack` is high, and the transfer completes on that edge.

Top module: `tso_store_buffer`

## Requirements
- R1: A store is accepted while fewer than `DEPTH` entries are queued. With `DEPTH` entries queued, `req_ready` is low for a store request until an entry drains.
- R2: Every accepted store produces exactly one memory write (`mem_we`=1) with the issued address and data, and the writes occur in issue order.
- R3: Once `mem_req` is high without `mem_ack`, on the next cycle `mem_req` is still high and `mem_we`, `mem_addr` and `mem_wdata` are unchanged.
- R4: A load whose address matches one or more queued stores raises `rsp_valid` in the cycle after acceptance, with the data of the most recently issued matching store, and issues no memory read.
- R5: A load that matches no queued store issues a memory read (`mem_we`=0) at the load address. `rsp_valid` is high in the cycle of `mem_ack`, with `rsp_data` equal to `mem_rdata`.
- R6: From the cycle after a load is accepted until its response, `req_ready` is low.
- R7: While a missing load is outstanding, no new store write is started on the memory port. A write that was already presented and not yet acknowledged completes before the read.
- R8: After reset the buffer is empty: `mem_req` and `rsp_valid` are low and `req_ready` is high.
- R9: Matching compares every address bit. A store whose address differs from the load address in any bit, including the top bit, never supplies load data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Request may transfer this cycle |
| req_load | input | 1 | 1 = load, 0 = store (a swap is issued as a store) |
| req_addr | input | ADDR_W | Word address of the request |
| req_data | input | DATA_W | Store data |
| rsp_valid | output | 1 | Load data valid, one-cycle pulse |
| rsp_data | output | DATA_W | Load data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write (store drain), 0 = read (missing load) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` on a read |

## Verification
A corrupted read or write pointer shows up at the next memory write as the wrong address or data, or as a write the bench never expected. It also shows up at the next forwarded load as data from the wrong entry. A wrong age comparison in the match logic returns an older store's data on the first load to an address that has been stored to twice. A stuck load state would hold `req_ready` low, or let a second drain start under a missing load. The memory model catches each of these within the cycle it occurs, across three memory latencies and a long mixed stream of loads and stores.

// File: rtl/tsob_pkg.sv
package tsob_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // accepting requests
    ST_HIT  = 2'd1,  // forwarded load answers this cycle
    ST_MISS = 2'd2   // load waiting on memory read
  } tsob_state_e;
endpackage

// File: rtl/tsob_fifo.sv
module tsob_fifo #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic [ADDR_W-1:0]                push_addr,
  input  logic [DATA_W-1:0]                push_data,
  input  logic                             pop,
  output logic [ADDR_W-1:0]                head_addr,
  output logic [DATA_W-1:0]                head_data,
  output logic [DEPTH-1:0][ADDR_W-1:0]     slot_addr,
  output logic [DEPTH-1:0][DATA_W-1:0]     slot_data,
  output logic [$clog2(DEPTH)-1:0]         rd_ptr,
  output logic [$clog2(DEPTH+1)-1:0]       count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [PW-1:0] wr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        slot_addr[wr_ptr] <= push_addr;
        slot_data[wr_ptr] <= push_data;
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_addr = slot_addr[rd_ptr];
  assign head_data = slot_data[rd_ptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != FULL)); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + 1'b1)); // R2
endmodule

// File: rtl/tsob_match.sv
module tsob_match #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0] slot_data,
  input  logic [$clog2(DEPTH)-1:0]     rd_ptr,
  input  logic [$clog2(DEPTH+1)-1:0]   count,
  input  logic [ADDR_W-1:0]            key,
  output logic                         hit,
  output logic [DATA_W-1:0]            hit_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][CW-1:0] age;
  logic [DEPTH-1:0]         match;

  // per slot: distance from the head (0 = oldest) and live address match
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [PW-1:0] IDX = PW'(i);
    always_comb begin
      if (IDX >= rd_ptr) age[i] = CW'(IDX - rd_ptr);
      else               age[i] = CW'(i + DEPTH) - CW'(rd_ptr);
    end
    assign match[i] = (age[i] < count) && (slot_addr[i] == key);
  end

  // youngest live match wins
  logic [CW-1:0] best_age;
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    best_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i] && (!hit || age[i] > best_age)) begin
        hit      = 1'b1;
        best_age = age[i];
        hit_data = slot_data[i];
      end
    end
  end
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_load,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  import tsob_pkg::*;

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  tsob_state_e state;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] fwd_q;
  logic              st_inflight;

  logic [ADDR_W-1:0]            head_addr;
  logic [DATA_W-1:0]            head_data;
  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
  logic [DEPTH-1:0][DATA_W-1:0] slot_data;
  logic [PW-1:0]                rd_ptr;
  logic [CW-1:0]                count;
  logic                         fwd_hit;
  logic [DATA_W-1:0]            fwd_data;

  logic accept, push, pop, sel_store, sel_load;

  assign req_ready = (state == ST_IDLE) && (req_load || count != FULL);
  assign accept    = req_valid && req_ready;
  assign push      = accept && !req_load;

  // memory port: a presented write is never withdrawn; a missing load
  // blocks new drains but waits for a write already in flight
  assign sel_store = (count != '0) && (state != ST_MISS || st_inflight);
  assign sel_load  = !sel_store && (state == ST_MISS);
  assign pop       = sel_store && mem_ack;

  assign mem_req   = sel_store || sel_load;
  assign mem_we    = sel_store;
  assign mem_addr  = sel_store ? head_addr : ld_addr;
  assign mem_wdata = head_data;

  assign rsp_valid = (state == ST_HIT) || (sel_load && mem_ack);
  assign rsp_data  = (state == ST_HIT) ? fwd_q : mem_rdata;

  tsob_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(req_addr), .push_data(req_data), .pop(pop),
    .head_addr(head_addr), .head_data(head_data),
    .slot_addr(slot_addr), .slot_data(slot_data),
    .rd_ptr(rd_ptr), .count(count)
  );

  tsob_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_match (
    .slot_addr(slot_addr), .slot_data(slot_data),
    .rd_ptr(rd_ptr), .count(count), .key(req_addr),
    .hit(fwd_hit), .hit_data(fwd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      ld_addr     <= '0;
      fwd_q       <= '0;
      st_inflight <= 1'b0;
    end else begin
      st_inflight <= sel_store && !mem_ack;
      case (state)
        ST_IDLE: if (accept && req_load) begin
          ld_addr <= req_addr;
          fwd_q   <= fwd_data;
          state   <= fwd_hit ? ST_HIT : ST_MISS;
        end
        ST_HIT:  state <= ST_IDLE;
        ST_MISS: if (sel_load && mem_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_wdata))); // R3
  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_load && fwd_hit) |=> (rsp_valid && !(mem_req && !mem_we))); // R4
  AST_LOAD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_load) |=> !req_ready); // R6
  AST_NO_NEW_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MISS && !(mem_req && mem_we)) |=>
      (state != ST_MISS || !(mem_req && mem_we))); // R7
  AST_RSP_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (state != ST_IDLE)); // R5
endmodule

// File: tb/tso_store_buffer_test.sv
`timescale 1ns/1ps
module tso_store_buffer_test;
  localparam int AW = 4, DW = 16, DEP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_load = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, rsp_valid, mem_req, mem_we;
  logic [DW-1:0] rsp_data, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #10 clk = ~clk; // 50 MHz

  tso_store_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP)) uut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model and expected store order
  logic [DW-1:0] mem [16];
  logic [AW-1:0] q_a [16];
  logic [DW-1:0] q_d [16];
  int q_hd = 0, q_cnt = 0;
  int lat = 0, wcnt = 0;
  bit hold = 0, prev_pend = 0, miss_active = 0;
  bit jp = 0;
  logic [AW-1:0] jp_a;
  logic pv_we; logic [AW-1:0] pv_a; logic [DW-1:0] pv_d;

  always @(negedge clk) begin
    jp = 0;
    if (!rst_n) begin
      mem_ack = 0; wcnt = 0; prev_pend = 0;
    end else if (mem_req) begin
      if (prev_pend)
        chk(mem_we == pv_we && mem_addr == pv_a && mem_wdata == pv_d,
            "R3 held request changed", {mem_we, 3'b0, mem_addr, mem_wdata}, {pv_we, 3'b0, pv_a, pv_d});
      else if (mem_we && miss_active)
        chk(0, "R7 drain started under missing load", 32'(mem_addr), 32'hFFFF);
      if (!hold && wcnt >= lat) begin
        mem_ack = 1; wcnt = 0;
        if (mem_we) begin
          chk(q_cnt > 0 && q_a[q_hd] == mem_addr && q_d[q_hd] == mem_wdata,
              "R2 write order", {12'b0, mem_addr, mem_wdata}, {12'b0, q_a[q_hd], q_d[q_hd]});
          mem[mem_addr] = mem_wdata;
          jp = 1; jp_a = mem_addr;
          q_hd = (q_hd + 1) % 16; q_cnt--;
        end else mem_rdata = mem[mem_addr];
      end else begin
        mem_ack = 0; wcnt++;
      end
      prev_pend = !mem_ack;
      pv_we = mem_we; pv_a = mem_addr; pv_d = mem_wdata;
    end else begin
      mem_ack = 0; wcnt = 0; prev_pend = 0;
    end
  end

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1; req_load = 0; req_addr = a; req_data = d;
    while (!req_ready) begin @(negedge clk); #1; end
    q_a[(q_hd + q_cnt) % 16] = a; q_d[(q_hd + q_cnt) % 16] = d; q_cnt++;
    @(posedge clk); @(negedge clk); #1;
    req_valid = 0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input string tag);
    logic [DW-1:0] e; bit h; bit got;
    req_valid = 1; req_load = 1; req_addr = a; req_data = '0;
    while (!req_ready) begin @(negedge clk); #1; end
    h = 0; e = mem[a];
    if (jp && jp_a == a) h = 1;
    for (int k = 0; k < q_cnt; k++)
      if (q_a[(q_hd + k) % 16] == a) begin h = 1; e = q_d[(q_hd + k) % 16]; end
    miss_active = !h;
    @(posedge clk); @(negedge clk); #1;
    req_valid = 0;
    chk(!req_ready, "R6 ready during load", 32'(req_ready), 0);
    if (h) begin
      chk(rsp_valid && rsp_data == e, {tag, " R4 forwarded data"}, {15'b0, rsp_valid, rsp_data}, {16'h1, e});
      chk(!(mem_req && !mem_we), "R4 no memory read on hit", 32'(mem_req), 0);
    end else begin
      got = 0;
      for (int w = 0; w < 60 && !got; w++) begin
        if (rsp_valid) begin
          got = 1;
          chk(rsp_data == mem[a], {tag, " R5 miss data"}, 32'(rsp_data), 32'(mem[a]));
          chk(mem_ack && !mem_we && mem_addr == a, "R5 read at load address",
              {mem_ack, mem_we, 26'b0, mem_addr}, {2'b10, 26'b0, a});
        end else begin
          @(negedge clk); #1;
        end
      end
      if (!got) chk(0, {tag, " R5 no response"}, 0, 1);
      miss_active = 0;
    end
  endtask

  logic [15:0] lf = 16'hACE1;

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'hA000 + 16'(i);
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk(req_ready && !mem_req && !rsp_valid, "R8 reset state",
        {req_ready, mem_req, rsp_valid}, 3'b100);

    // fill with memory held, then probe full and forwarding
    hold = 1;
    do_store(4'd3, 16'h0011);
    do_store(4'd5, 16'h0022);
    do_store(4'd3, 16'h0033);
    do_store(4'd9, 16'h0044);
    req_valid = 1; req_load = 0; req_addr = 4'd1; req_data = 16'h0055;
    for (int i = 0; i < 3; i++) begin
      chk(!req_ready, "R1 store stalls when full", 32'(req_ready), 0);
      @(negedge clk); #1;
    end
    req_valid = 0;
    do_load(4'd3, "R4 youngest of two");
    do_load(4'd5, "R4 single match");
    do_load(4'd9, "R4 tail match");
    // top-bit alias of queued address 3 must miss; release memory later
    fork
      do_load(4'd11, "R9 alias miss R7");
      begin repeat (4) @(negedge clk); #2; hold = 0; lat = 1; end
    join
    do_store(4'd1, 16'h0055);
    chk(1, "R1 store accepted after drain", 0, 0);

    // mixed sweep over memory latencies
    for (int l = 0; l < 3; l++) begin
      lat = l;
      for (int n = 0; n < 200; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[1:0] == 2'b00) do_load({lf[7] & lf[8], lf[6:4]}, "sweep");
        else do_store({1'b0, lf[6:4]}, lf ^ 16'(n));
      end
    end

    // drain everything, then read back all addresses through memory
    lat = 1;
    for (int w = 0; w < 200 && q_cnt != 0; w++) @(negedge clk);
    repeat (3) @(negedge clk); #1;
    chk(q_cnt == 0 && !mem_req, "R2 buffer fully drained", 32'(q_cnt), 0);
    for (int i = 0; i < 16; i++) do_load(4'(i), "final");

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule